// File: doc/BRIEF.md
# Flash Read Multiplexer with Identification Codes and Write Status

This block produces the byte that a parallel flash memory model returns on a read. The array storage sits outside it and presents the byte at the current read address. The block then chooses among three sources for each read. In normal operation it passes the array byte through. In identification mode, a few probe addresses return fixed vendor and device codes or the lockout state of the two boot regions. While the memory commits a loaded page to the array, every read returns write-status bits instead of array data.

Software polls for the end of a commit in one of two ways. It can watch bit 7, which shows the complement of bit 7 of the last byte it loaded until the commit finishes. It can also watch bit 6, which flips on every read during the commit and stops flipping when the commit ends. Each read strobe captures the selected byte into an output register. The register holds that byte until the next strobe.

Top module: `flash_read_mux`

## Requirements
- R1: After reset, `rdData` is 0x00.
- R2: When `busy` and `idMode` are both low, a strobed read returns `arrData` unchanged on `rdData` in the cycle after the strobe.
- R3: When `idMode` is high and `busy` is low, address 0x00000 returns 0xDA and address 0x00001 returns 0x45.
- R4: When `idMode` is high and `busy` is low, address 0x00002 returns 0xFF if `lockLow` is set and 0xFE if it is clear. Address 0x3FFF2 (the top of the address space minus 13) does the same for `lockHigh`.
- R5: When `idMode` is high and `busy` is low, any address other than the four probe addresses returns `arrData`.
- R6: While `busy` is high, bit 7 of a strobed read equals the inverse of bit 7 of `lastByte`.
- R7: While `busy` is high, the first read in each commit returns bit 6 as 0, and each later read in the same commit returns the inverse of the previous read's bit 6.
- R8: While `busy` is high, bits 5 to 0 of a strobed read are 0.
- R9: Once `busy` is low, reads return true data again: bit 7 is no longer inverted and bit 6 no longer alternates.
- R10: `busy` takes priority over `idMode`, so a read during a commit returns status even in identification mode.
- R11: When `rdStrobe` is low, `rdData` keeps its value whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdStrobe | input | 1 | Captures one read at this edge |
| rdAddr | input | 18 | Byte address of the read |
| arrData | input | 8 | Array byte stored at `rdAddr` |
| busy | input | 1 | Internal page commit in progress |
| lastByte | input | 8 | Last byte loaded before the commit |
| lockLow | input | 1 | Lower boot region is locked |
| lockHigh | input | 1 | Upper boot region is locked |
| idMode | input | 1 | Identification mode is active |
| rdData | output | 8 | Read result, registered |

## Verification
The bench sweeps many addresses with a computed array pattern, in normal mode and in identification mode. This separates pass-through from code lookup and confirms that only the four probe addresses are decoded. It runs all four lockout flag combinations against both region probes, so a swapped or inverted flag is exposed. Commits are tried with both polarities of the last byte's bit 7 and with long runs of reads, which checks the bit 7 inversion and the bit 6 sequence. It also starts several commits back to back, which shows whether bit 6 restarts at 0 for each commit. Reads just after a commit ends, and reads in identification mode during a commit, confirm that true data returns and that commit status takes priority.

// File: rtl/rdmux_pkg.sv
package rdmux_pkg;

  typedef enum logic [1:0] {
    SRC_ARRAY  = 2'd0,
    SRC_ID     = 2'd1,
    SRC_STATUS = 2'd2
  } rdSrc_e;

  typedef struct packed {
    logic   load;
    rdSrc_e src;
    logic   togBit;
  } rdCtl_t;

endpackage

// File: rtl/rdmux_ctrl.sv
module rdmux_ctrl
  import rdmux_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   rdStrobe,
  input  logic   busy,
  input  logic   idMode,
  output rdCtl_t ctl
);

  logic toggleQ;

  // Held at zero while idle, so every commit starts from the same phase.
  always_ff @(posedge clk) begin
    if (!rstN)         toggleQ <= 1'b0;
    else if (!busy)    toggleQ <= 1'b0;
    else if (rdStrobe) toggleQ <= ~toggleQ;
  end

  always_comb begin
    ctl.load   = rdStrobe;
    ctl.togBit = toggleQ;
    if (busy)        ctl.src = SRC_STATUS;
    else if (idMode) ctl.src = SRC_ID;
    else             ctl.src = SRC_ARRAY;
  end

endmodule

// File: rtl/rdmux_dp.sv
module rdmux_dp
  import rdmux_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] MFR_CODE = 8'hDA,
  parameter logic [DATA_W-1:0] DEV_CODE = 8'h45
) (
  input  logic              clk,
  input  logic              rstN,
  input  rdCtl_t            ctl,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] arrData,
  input  logic [DATA_W-1:0] lastByte,
  input  logic              lockLow,
  input  logic              lockHigh,
  output logic [DATA_W-1:0] rdData
);

  localparam logic [ADDR_W-1:0] ADDR_MFR  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_DEV  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_LLO  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] ADDR_LHI  = {ADDR_W{1'b1}} - ADDR_W'(13);
  localparam logic [DATA_W-1:0] CODE_LOCK = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] CODE_OPEN = {{(DATA_W-1){1'b1}}, 1'b0};

  logic [DATA_W-1:0] idByte;
  logic [DATA_W-1:0] statByte;
  logic [DATA_W-1:0] nextByte;

  always_comb begin
    unique case (rdAddr)
      ADDR_MFR: idByte = MFR_CODE;
      ADDR_DEV: idByte = DEV_CODE;
      ADDR_LLO: idByte = lockLow  ? CODE_LOCK : CODE_OPEN;
      ADDR_LHI: idByte = lockHigh ? CODE_LOCK : CODE_OPEN;
      default:  idByte = arrData;
    endcase
  end

  always_comb begin
    statByte             = '0;
    statByte[DATA_W-1]   = ~lastByte[DATA_W-1];
    statByte[DATA_W-2]   = ctl.togBit;
  end

  always_comb begin
    unique case (ctl.src)
      SRC_STATUS: nextByte = statByte;
      SRC_ID:     nextByte = idByte;
      default:    nextByte = arrData;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)         rdData <= '0;
    else if (ctl.load) rdData <= nextByte;
  end

endmodule

// File: rtl/flash_read_mux.sv
module flash_read_mux
  import rdmux_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdStrobe,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] arrData,
  input  logic              busy,
  input  logic [DATA_W-1:0] lastByte,
  input  logic              lockLow,
  input  logic              lockHigh,
  input  logic              idMode,
  output logic [DATA_W-1:0] rdData
);

  rdCtl_t ctl;

  rdmux_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .rdStrobe (rdStrobe),
    .busy     (busy),
    .idMode   (idMode),
    .ctl      (ctl)
  );

  rdmux_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .rdAddr   (rdAddr),
    .arrData  (arrData),
    .lastByte (lastByte),
    .lockLow  (lockLow),
    .lockHigh (lockHigh),
    .rdData   (rdData)
  );

endmodule

// File: rtl/rdmux_chk.sv
module rdmux_chk #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdStrobe,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [DATA_W-1:0] arrData,
  input logic              busy,
  input logic [DATA_W-1:0] lastByte,
  input logic              idMode,
  input logic [DATA_W-1:0] rdData
);

  logic statRdQ;
  logic seenQ;
  logic prevB6Q;
  logic seenEff;
  logic prevEff;
  logic expB6;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statRdQ <= 1'b0;
      seenQ   <= 1'b0;
      prevB6Q <= 1'b0;
    end else begin
      statRdQ <= rdStrobe && busy;
      if (statRdQ) begin
        prevB6Q <= rdData[DATA_W-2];
        seenQ   <= busy;
      end else if (!busy) begin
        seenQ   <= 1'b0;
      end
    end
  end

  assign seenEff = seenQ || statRdQ;
  assign prevEff = statRdQ ? rdData[DATA_W-2] : prevB6Q;
  assign expB6   = seenEff ? ~prevEff : 1'b0;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !rdStrobe |=> $stable(rdData)); // R11

  AST_STAT_INV7: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe && busy |=> rdData[DATA_W-1] == ~$past(lastByte[DATA_W-1])); // R6

  AST_STAT_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe && busy |=> rdData[DATA_W-2] == $past(expB6)); // R7

  AST_STAT_LOWZERO: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe && busy |=> rdData[DATA_W-3:0] == '0); // R8

  AST_ARRAY_PASS: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe && !busy && !idMode |=> rdData == $past(arrData)); // R2

  AST_ID_MFR: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe && !busy && idMode && rdAddr == '0 |=> rdData == 8'hDA); // R3

endmodule

bind flash_read_mux rdmux_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .rdStrobe (rdStrobe),
  .rdAddr   (rdAddr),
  .arrData  (arrData),
  .busy     (busy),
  .lastByte (lastByte),
  .idMode   (idMode),
  .rdData   (rdData)
);

// File: tb/sim_flash_read_mux.sv
`timescale 1ns/1ps
module sim_flash_read_mux;

  logic        clk = 1'b0;
  logic        rstN;
  logic        rdStrobe;
  logic [17:0] rdAddr;
  logic [7:0]  arrData;
  logic        busy;
  logic [7:0]  lastByte;
  logic        lockLow;
  logic        lockHigh;
  logic        idMode;
  logic [7:0]  rdData;

  int checks = 0;
  int errors = 0;
  logic expTog;

  always #2.5 clk = ~clk;

  // Array pattern computed from the address.
  assign arrData = rdAddr[7:0] ^ {rdAddr[15:8]} ^ {6'd0, rdAddr[17:16]} ^ 8'h5A;

  flash_read_mux u0 (
    .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .rdAddr(rdAddr),
    .arrData(arrData), .busy(busy), .lastByte(lastByte),
    .lockLow(lockLow), .lockHigh(lockHigh), .idMode(idMode), .rdData(rdData)
  );

  function automatic logic [7:0] arrOf(input logic [17:0] a);
    return a[7:0] ^ a[15:8] ^ {6'd0, a[17:16]} ^ 8'h5A;
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  // Drive at a falling edge, strobe across one rising edge, result visible at next fall.
  task automatic doRead(input logic [17:0] a);
    rdAddr   = a;
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  task automatic startCommit(input logic [7:0] lb);
    busy = 1'b0;
    @(negedge clk);
    lastByte = lb;
    busy     = 1'b1;
    expTog   = 1'b0;
  endtask

  task automatic statusRun(input int n, input logic [7:0] lb, input string tag7, input string tag6);
    for (int i = 0; i < n; i++) begin
      doRead(18'(i * 37));
      check(tag7, {7'd0, rdData[7]}, {7'd0, ~lb[7]});
      check(tag6, {7'd0, rdData[6]}, {7'd0, expTog});
      check("R8", {2'd0, rdData[5:0]}, 8'd0);
      expTog = ~expTog;
    end
  endtask

  initial begin
    #150000;
    errors++;
    $display("FAIL watchdog: got hang expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; rdStrobe = 1'b0; rdAddr = '0; busy = 1'b0;
    lastByte = '0; lockLow = 1'b0; lockHigh = 1'b0; idMode = 1'b0;
    expTog = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", rdData, 8'h00);
    rstN = 1'b1;
    @(negedge clk);

    // R2: normal sweep
    for (int a = 0; a < 600; a++) begin
      logic [17:0] ad;
      ad = 18'(a * 439 + 3);
      doRead(ad);
      check("R2", rdData, arrOf(ad));
    end

    // R3/R4/R5: identification mode
    idMode = 1'b1;
    doRead(18'h00000); check("R3", rdData, 8'hDA);
    doRead(18'h00001); check("R3", rdData, 8'h45);
    for (int k = 0; k < 4; k++) begin
      lockLow  = k[0];
      lockHigh = k[1];
      doRead(18'h00002); check("R4", rdData, lockLow  ? 8'hFF : 8'hFE);
      doRead(18'h3FFF2); check("R4", rdData, lockHigh ? 8'hFF : 8'hFE);
    end
    for (int a = 3; a < 300; a++) begin
      doRead(18'(a));
      check("R5", rdData, arrOf(18'(a)));
    end
    doRead(18'h3FFF1); check("R5", rdData, arrOf(18'h3FFF1));
    doRead(18'h3FFF3); check("R5", rdData, arrOf(18'h3FFF3));
    doRead(18'h20002); check("R5", rdData, arrOf(18'h20002));
    idMode = 1'b0;

    // R6/R7/R8: commits with both bit-7 polarities, restart per commit
    startCommit(8'h80);
    statusRun(9, 8'h80, "R6", "R7");
    startCommit(8'h3C);
    statusRun(6, 8'h3C, "R6", "R7");
    // gaps between reads keep the sequence
    for (int i = 0; i < 4; i++) begin
      repeat (3) @(negedge clk);
      doRead(18'h00100);
      check("R7", {7'd0, rdData[6]}, {7'd0, expTog});
      expTog = ~expTog;
    end

    // R9: commit ends, true data returns, no toggling
    busy = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      doRead(18'h000F0);
      check("R9", rdData, arrOf(18'h000F0));
    end

    // R10: status over identification mode
    idMode = 1'b1;
    startCommit(8'hFF);
    doRead(18'h00000);
    check("R10", rdData, 8'h00);
    doRead(18'h00001);
    check("R10", rdData, 8'h40);
    busy = 1'b0;
    @(negedge clk);
    doRead(18'h00000); check("R10", rdData, 8'hDA);
    idMode = 1'b0;

    // R11: no strobe, inputs move, output holds
    doRead(18'h00077);
    for (int i = 0; i < 8; i++) begin
      rdAddr = 18'(i * 1031); busy = i[0]; idMode = i[1]; lastByte = 8'(i * 17);
      @(negedge clk);
      check("R11", rdData, arrOf(18'h00077));
    end
    busy = 1'b0; idMode = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule